// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A single-port static memory of 256 words by 32 bits, split into four 8-bit byte lanes. Every input is captured on the rising clock edge: the address, the write data and all the control strobes. The read path is flow-through. Once an address has been captured, its word appears on the bidirectional data bus within that same cycle, with no output register in between.

A burst begins when either of two address strobes is asserted. One strobe is for a processor and the other is for a cache controller. The strobe loads the external address. After that, a 2-bit counter generates the remaining three addresses of the group of four, and it moves only while the advance input is asserted. A mode input chooses the order. Low gives a linear order, which adds the count to the low address bits modulo 4. High gives an interleaved order, which XORs the count with those bits. A write stores all lanes through a global write input, or selected lanes through a byte-write enable and per-lane selects. The bus is driven only on read cycles with the output enable asserted.

Top module: `burst_sram`

## Requirements
- R1: The address, write data and controls are sampled on the rising edge of `clk`. On a read, the word at the sampled address is driven on `data_io` during the cycle that begins at that edge.
- R2: An asserted strobe with `cs_n` low loads `addr` as the burst base and clears the counter. An asserted strobe with `cs_n` high deselects the block. While deselected, `data_io` is high-impedance and no write takes place until a strobe arrives with `cs_n` low.
- R3: In a cycle without a strobe, the counter advances by one when `step_n` is low and holds when it is high. After the fourth address it wraps back to the first.
- R4: With `order_sel` = 0, address bits [1:0] equal (base[1:0] + count) mod 4.
- R5: With `order_sel` = 1, address bits [1:0] equal base[1:0] XOR count. In both orders, bits [7:2] stay equal to the base for the whole burst.
- R6: With `wr_all_n` low, all four lanes are written, whatever the value of `lane_sel_n`.
- R7: With `wr_all_n` high and `wr_en_n` low, exactly the lanes i with `lane_sel_n[i]` low are written. Lane i is bits [8i+7:8i]. With no lane selected, the cycle writes nothing.
- R8: With both `wr_all_n` and `wr_en_n` high, the cycle is a read and the array does not change.
- R9: When both strobes are asserted together, the processor strobe `strb_cpu_n` takes priority. A cycle it starts is always a read and ignores the write controls. A cycle started by `strb_ctl_n` alone obeys them.
- R10: A strobe always restarts the burst, even while `step_n` is low.
- R11: `data_io` is driven only when the block is selected, the registered cycle is a read, and `out_en_n` is low. In every other case it is high-impedance. A write to a word is visible to a read of that word in the very next cycle.
- R12: While `rst_n` is low, the block is deselected and `data_io` is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | External word address |
| strb_cpu_n | input | 1 | Processor-side burst strobe, active low, has priority |
| strb_ctl_n | input | 1 | Controller-side burst strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| cs_n | input | 1 | Chip select, sampled with a strobe, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data_io | inout | 32 | Shared write-data and read-data bus |

## Verification
Two events can land in the same cycle. In one, a strobe arrives while the advance input is asserted. In the other, both strobes arrive together while a write is requested. The bench provokes the first in the middle of a running burst and the second with a global write on a word that already holds known data. The reference model then decides each case: the burst must restart at the new address, and the word must be unchanged when it is read back. A write followed at once by a read of the same word is also provoked, and the new value must appear one cycle later.

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic              order_sel,
  input  logic              cs_n,
  input  logic              wr_all_n,
  input  logic              wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  inout  wire  [DATA_W-1:0] data_io
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              active_q, wr_q, mode_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata;
  logic [1:0]        lo;
  logic [ADDR_W-1:0] cur_addr;

  wire strobe = !strb_cpu_n || !strb_ctl_n;
  wire wr_req = !wr_all_n || !wr_en_n;
  wire [LANES-1:0] mask_in = !wr_all_n ? {LANES{1'b1}} : ~lane_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      mode_q   <= 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      wdata_q  <= '0;
    end else begin
      mode_q  <= order_sel;
      wdata_q <= data_io;
      mask_q  <= mask_in;
      if (strobe) begin
        active_q <= !cs_n;
        base_q   <= addr;
        cnt_q    <= '0;
        wr_q     <= !cs_n && strb_cpu_n && wr_req;
      end else begin
        if (!step_n) cnt_q <= cnt_q + 2'd1;
        wr_q <= active_q && wr_req;
      end
    end
  end

  assign lo       = mode_q ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  assign cur_addr = {base_q[ADDR_W-1:2], lo};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk)
      if (wr_q && mask_q[g]) arr[cur_addr] <= wdata_q[g*LANE_W +: LANE_W];
    assign rdata[g*LANE_W +: LANE_W] = arr[cur_addr];
  end

  wire drive = active_q && !wr_q && !out_en_n;
  assign data_io = drive ? rdata : {DATA_W{1'bz}};
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              step_n,
  input logic              order_sel,
  input logic              cs_n,
  input logic              mode_q,
  input logic              active_q,
  input logic              wr_q,
  input logic [ADDR_W-1:0] cur_addr
);
  wire strobe = !strb_cpu_n || !strb_ctl_n;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !cs_n |=> active_q && cur_addr == $past(addr));

  p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && cs_n |=> !active_q);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe && step_n && order_sel == mode_q |=> cur_addr == $past(cur_addr));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe && !step_n && !order_sel && !mode_q
    |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

  p_cpu_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_cpu_n |=> !wr_q);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
  .strb_ctl_n(strb_ctl_n), .step_n(step_n), .order_sel(order_sel),
  .cs_n(cs_n), .mode_q(mode_q), .active_q(active_q), .wr_q(wr_q),
  .cur_addr(cur_addr)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, step_n = 1'b1, order_sel = 1'b0;
  logic cs_n = 1'b0, wr_all_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b0;
  logic [3:0]  lane_sel_n = 4'hF;
  logic [31:0] drv = '0;
  logic        drv_en = 1'b0;
  logic        oe_want = 1'b1;
  wire  [31:0] data_io;
  assign data_io = drv_en ? drv : 32'bz;

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .step_n(step_n), .order_sel(order_sel),
    .cs_n(cs_n), .wr_all_n(wr_all_n), .wr_en_n(wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .data_io(data_io)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R12";

  logic [31:0] ref_mem [256];
  bit m_act = 0, m_wr = 0, m_mode = 0;
  int m_base = 0, m_cnt = 0;
  logic [3:0]  m_mask = '0;
  logic [31:0] m_wd = '0;

  function automatic int m_cur();
    int lo;
    lo = m_mode ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4);
    return (m_base & 'hFC) | lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit wreq;
    if (!rst_n) begin
      m_act = 0; m_wr = 0;
    end else begin
      if (m_wr)
        for (int l = 0; l < 4; l++)
          if (m_mask[l]) ref_mem[m_cur()][8*l +: 8] = m_wd[8*l +: 8];
      wreq   = !wr_all_n || !wr_en_n;
      m_wd   = drv;
      m_mode = order_sel;
      m_mask = !wr_all_n ? 4'hF : ~lane_sel_n;
      if (!strb_cpu_n || !strb_ctl_n) begin
        m_act  = !cs_n;
        m_base = addr;
        m_cnt  = 0;
        m_wr   = !cs_n && strb_cpu_n && wreq;
      end else begin
        if (!step_n) m_cnt = (m_cnt + 1) % 4;
        m_wr = m_act && wreq;
      end
    end
  end

  // every cycle: bus value against the model (R1 timing, R11 drive rules)
  task automatic compare();
    logic [31:0] exp;
    if (drv_en) exp = drv;
    else if (!m_act || m_wr || out_en_n) exp = 32'bz;
    else exp = ref_mem[m_cur()];
    checks++;
    if (data_io !== exp) begin
      fails++;
      $display("FAIL %s data_io=%h expected=%h", tag, data_io, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic op(input bit cpu, input bit ctl, input bit step, input bit wa,
                    input bit we, input logic [3:0] sel, input logic [7:0] a,
                    input logic [31:0] d);
    strb_cpu_n = !cpu; strb_ctl_n = !ctl; step_n = !step;
    wr_all_n = !wa; wr_en_n = !we; lane_sel_n = ~sel;
    addr = a; drv = d; drv_en = wa || we;
    out_en_n = (wa || we) ? 1'b1 : !oe_want;
    tick();
  endtask

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h3C, a + 8'd7};
  endfunction

  initial begin
    repeat (3) tick();
    tag = "R12";
    tick();
    @(negedge clk); rst_n = 1'b1;
    tick();

    tag = "R6";
    order_sel = 1'b0;
    for (int b = 0; b < 64; b++) begin
      op(0, 1, 0, 1, 0, 4'h0, 8'(b*4), pat(8'(b*4)));
      for (int k = 1; k < 4; k++)
        op(0, 0, 1, 1, 0, 4'h0, 8'h00, pat(8'(b*4+k)));
    end
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);

    tag = "R1";
    op(1, 0, 0, 0, 0, 4'h0, 8'h17, 32'h0);

    for (int m = 0; m < 2; m++) begin
      order_sel = m[0];
      tag = m ? "R5" : "R4";
      for (int off = 0; off < 4; off++) begin
        op(1, 0, 0, 0, 0, 4'h0, 8'(8'h40 + m*32 + off*4 + off), 32'h0);
        for (int s = 0; s < 3; s++) op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
        tag = "R3";
        op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
        op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
        op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
        tag = m ? "R5" : "R4";
      end
    end
    order_sel = 1'b0;

    tag = "R7";
    for (int m = 0; m < 16; m++) begin
      op(0, 1, 0, 0, 1, 4'(m), 8'(8'h80 + m), 32'hC0DE0000 ^ (32'(m) * 32'h11111111));
      op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
      op(1, 0, 0, 0, 0, 4'h0, 8'(8'h80 + m), 32'h0);
    end

    tag = "R8";
    op(0, 1, 0, 0, 0, 4'h0, 8'h90, 32'h0);
    op(0, 0, 1, 0, 0, 4'hF, 8'h00, 32'h0);
    op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    op(1, 0, 0, 0, 0, 4'h0, 8'h91, 32'h0);

    tag = "R9";
    op(1, 1, 0, 1, 0, 4'h0, 8'hA0, 32'h12345678);
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
    op(1, 0, 0, 0, 0, 4'h0, 8'hA0, 32'h0);
    op(1, 1, 0, 0, 1, 4'hF, 8'hA1, 32'h87654321);
    op(0, 1, 0, 0, 0, 4'h0, 8'hA1, 32'h0);

    tag = "R10";
    order_sel = 1'b1;
    op(1, 0, 0, 0, 0, 4'h0, 8'hB1, 32'h0);
    op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    op(1, 0, 1, 0, 0, 4'h0, 8'hC2, 32'h0);
    op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    op(0, 1, 1, 0, 0, 4'h0, 8'hC7, 32'h0);
    op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);
    order_sel = 1'b0;

    tag = "R11";
    oe_want = 1'b0;
    op(1, 0, 0, 0, 0, 4'h0, 8'h20, 32'h0);
    oe_want = 1'b1;
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
    op(0, 1, 0, 1, 0, 4'h0, 8'hD0, 32'hFACEB00C);
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
    op(0, 0, 1, 0, 1, 4'h5, 8'h00, 32'h0BADF00D);
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);

    tag = "R2";
    cs_n = 1'b1;
    op(1, 0, 0, 0, 0, 4'h0, 8'hE0, 32'h0);
    cs_n = 1'b0;
    op(0, 0, 1, 1, 0, 4'h0, 8'h00, 32'hFFFF0000);
    op(0, 0, 0, 1, 0, 4'h0, 8'h00, 32'h0000FFFF);
    op(0, 0, 0, 0, 0, 4'h0, 8'h00, 32'h0);
    op(1, 0, 0, 0, 0, 4'h0, 8'hE0, 32'h0);
    for (int s = 0; s < 3; s++) op(0, 0, 1, 0, 0, 4'h0, 8'h00, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule